// File: doc/BRIEF.md
# Per-CPU Interrupt Pending and Level Tracker

This block sits between the interrupt state and enable storage and the CPU-facing delivery logic of an interrupt controller. It takes each CPU's private line, enable and trigger-mode vectors, the shared line, enable and trigger-mode vectors, a per-CPU target bit for every shared interrupt, and a global distributor enable. From these it works out, for every CPU, whether any interrupt can be delivered to it. It then offers one interrupt ID per CPU through a valid/ready handshake.

Edge-triggered interrupts are latched on a rising line and consumed when they are handed over. Level-triggered interrupts are not latched. Once one is handed over it is marked in service, and its line is ignored until an end-of-interrupt notice names it. After that notice the line is looked at again. A shared interrupt is routed to exactly one CPU: the lowest-indexed CPU whose target bit is set. It counts toward no other CPU.

All inputs are registered once on entry. The pending and offer outputs are derived only from internal registers, so no path runs from an input straight to an output.

Top module: `irq_pend_track`

## Requirements
- R1: While reset is high, and in the first cycle after it is released with all lines low, `pending` and `offer_valid` are 0 for every CPU.
- R2: A private interrupt i of CPU c is deliverable to CPU c only while its state and its enable bit `priv_en[c*NP+i]` are both 1. The state is the line for level mode and the latch for edge mode. CPU c then offers it, one clock after the inputs are applied. Private interrupts have IDs 0..NP-1.
- R3: Shared interrupt j has ID NP+j. It is deliverable only while its state and `shr_en[j]` are 1. It is offered only to the lowest-indexed CPU c with `shr_target[c*NS+j]` set, and never to any other CPU.
- R4: While the registered distributor enable is 0, every `pending` and `offer_valid` bit is 0. One clock after the enable returns to 1, pending interrupts are offered again.
- R5: Each CPU offers the lowest-numbered deliverable ID, and `pending[c]` equals `offer_valid[c]`.
- R6: A transfer happens on a clock edge where `offer_valid[c]` and `take_ready[c]` are both 1. `offer_eoi[c]` is 1 when the offered interrupt is level mode (config bit 0) and 0 when it is edge mode (config bit 1).
- R7: In edge mode, a 0-to-1 line change sets a latch. A transfer clears the latch. A line that stays high causes no further offer until it falls and rises again.
- R8: After a level interrupt is transferred, it is not offered again until an EOI with its CPU index and ID arrives. After that EOI it is offered again in the next cycle if its line is still high, and not offered if the line is low.
- R9: An EOI whose CPU index differs from the owner of a private interrupt leaves that interrupt in service.
- R10: While `take_ready[c]` is 0, an offer stays valid with the same ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_en | input | 1 | Global distributor enable |
| priv_line | input | NC*NP | Private line state, bit c*NP+i |
| priv_en | input | NC*NP | Private enable bits |
| priv_cfg | input | NC*NP | Private trigger mode, 1 edge, 0 level |
| shr_line | input | NS | Shared line state |
| shr_en | input | NS | Shared enable bits |
| shr_cfg | input | NS | Shared trigger mode, 1 edge, 0 level |
| shr_target | input | NC*NS | Shared target bits, bit c*NS+j |
| take_ready | input | NC | Per-CPU ready for the offered ID |
| eoi_valid | input | 1 | One-cycle end-of-interrupt strobe |
| eoi_cpu | input | CW | CPU index of the EOI |
| eoi_id | input | IDW | Interrupt ID of the EOI |
| offer_valid | output | NC | Per-CPU offer valid |
| offer_id | output | NC*IDW | Offered ID of CPU c at bits c*IDW +: IDW |
| offer_eoi | output | NC | Offered interrupt needs an EOI (level mode) |
| pending | output | NC | Per-CPU any-deliverable summary |

## Verification
A change on any line, enable, config, target or distributor-enable input shows at the outputs right after the first rising edge that samples it. The bench therefore applies every stimulus one time unit after an edge, waits one edge, and samples one time unit later. A transfer or an EOI updates the latch and in-service state at the edge that carries it, so the withdrawn or renewed offer is checked just after that same edge. The claim that a high line stays ignored is checked by holding the line and sampling over several further cycles.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  function automatic int idw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ipt_pick.sv
module ipt_pick #(
  parameter int N  = 24,
  parameter int IW = 5
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/ipt_route.sv
module ipt_route #(
  parameter int NC = 2,
  parameter int NS = 16
) (
  input  logic [NC*NS-1:0] tgt,
  output logic [NC*NS-1:0] route
);
  always_comb begin
    logic found;
    route = '0;
    for (int j = 0; j < NS; j++) begin
      found = 1'b0;
      for (int c = 0; c < NC; c++) begin
        route[c*NS+j] = tgt[c*NS+j] & ~found;
        found = found | tgt[c*NS+j];
      end
    end
  end
endmodule

// File: rtl/ipt_cpu.sv
module ipt_cpu #(
  parameter int NP    = 8,
  parameter int NS    = 16,
  parameter int IDW   = 5,
  parameter int CW    = 1,
  parameter int MYIDX = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dist_en_q,
  input  logic [NP-1:0]  p_line,
  input  logic [NP-1:0]  p_en,
  input  logic [NP-1:0]  p_cfg,
  input  logic [NS-1:0]  s_state,
  input  logic [NS-1:0]  s_en,
  input  logic [NS-1:0]  s_route,
  input  logic [NS-1:0]  s_cfg,
  input  logic           ready,
  input  logic           eoi_valid,
  input  logic [CW-1:0]  eoi_cpu,
  input  logic [IDW-1:0] eoi_id,
  output logic           offer_valid,
  output logic [IDW-1:0] offer_id,
  output logic           offer_eoi,
  output logic           pending,
  output logic           take
);
  localparam int NT = NP + NS;

  logic [NP-1:0] p_line_q, p_en_q, p_cfg_q, p_pend, p_act;
  logic [NP-1:0] p_state, p_take, p_eoi, p_rise;
  logic [NT-1:0] deliv, cfg_all;
  logic          any;
  logic [IDW-1:0] pick_id;

  assign p_state = (p_line_q & ~p_act & ~p_cfg_q) | (p_pend & p_cfg_q);
  assign deliv   = {s_state & s_en & s_route, p_state & p_en_q};
  assign cfg_all = {s_cfg, p_cfg_q};

  ipt_pick #(.N(NT), .IW(IDW)) u_pick (.vec(deliv), .any(any), .idx(pick_id));

  assign offer_valid = dist_en_q & any;
  assign pending     = dist_en_q & (|deliv);
  assign offer_id    = pick_id;
  assign offer_eoi   = offer_valid & ~cfg_all[pick_id];
  assign take        = offer_valid & ready;
  assign p_rise      = p_line & ~p_line_q & p_cfg;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      p_take[i] = take && (pick_id == IDW'(i));
      p_eoi[i]  = eoi_valid && (eoi_cpu == CW'(MYIDX)) && (eoi_id == IDW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_line_q <= '0;
      p_en_q   <= '0;
      p_cfg_q  <= '0;
      p_pend   <= '0;
      p_act    <= '0;
    end else begin
      p_line_q <= p_line;
      p_en_q   <= p_en;
      p_cfg_q  <= p_cfg;
      p_pend   <= (p_pend & ~(p_take & p_cfg_q)) | p_rise;
      p_act    <= (p_act & ~p_eoi) | (p_take & ~p_cfg_q);
    end
  end
endmodule

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
  parameter int NC = 2,
  parameter int NP = 8,
  parameter int NS = 16,
  localparam int IDW = ipt_pkg::idw(NP + NS),
  localparam int CW  = ipt_pkg::idw(NC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dist_en,
  input  logic [NC*NP-1:0]  priv_line,
  input  logic [NC*NP-1:0]  priv_en,
  input  logic [NC*NP-1:0]  priv_cfg,
  input  logic [NS-1:0]     shr_line,
  input  logic [NS-1:0]     shr_en,
  input  logic [NS-1:0]     shr_cfg,
  input  logic [NC*NS-1:0]  shr_target,
  input  logic [NC-1:0]     take_ready,
  input  logic              eoi_valid,
  input  logic [CW-1:0]     eoi_cpu,
  input  logic [IDW-1:0]    eoi_id,
  output logic [NC-1:0]     offer_valid,
  output logic [NC*IDW-1:0] offer_id,
  output logic [NC-1:0]     offer_eoi,
  output logic [NC-1:0]     pending
);
  logic              dist_en_q;
  logic [NS-1:0]     s_line_q, s_en_q, s_cfg_q, s_pend, s_act;
  logic [NS-1:0]     s_state, s_taken, s_eoi, s_rise;
  logic [NC*NS-1:0]  s_tgt_q, s_route;
  logic [NC-1:0]     take;
  logic [IDW-1:0]    cpu_id [NC];

  ipt_route #(.NC(NC), .NS(NS)) u_route (.tgt(s_tgt_q), .route(s_route));

  assign s_state = (s_line_q & ~s_act & ~s_cfg_q) | (s_pend & s_cfg_q);
  assign s_rise  = shr_line & ~s_line_q & shr_cfg;

  for (genvar c = 0; c < NC; c++) begin : g_cpu
    ipt_cpu #(.NP(NP), .NS(NS), .IDW(IDW), .CW(CW), .MYIDX(c)) u_cpu (
      .clk(clk), .rst(rst), .dist_en_q(dist_en_q),
      .p_line(priv_line[c*NP +: NP]), .p_en(priv_en[c*NP +: NP]),
      .p_cfg(priv_cfg[c*NP +: NP]),
      .s_state(s_state), .s_en(s_en_q), .s_route(s_route[c*NS +: NS]),
      .s_cfg(s_cfg_q), .ready(take_ready[c]),
      .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
      .offer_valid(offer_valid[c]), .offer_id(cpu_id[c]),
      .offer_eoi(offer_eoi[c]), .pending(pending[c]), .take(take[c])
    );
    assign offer_id[c*IDW +: IDW] = cpu_id[c];
  end

  always_comb begin
    s_taken = '0;
    for (int j = 0; j < NS; j++) begin
      s_eoi[j] = eoi_valid && (eoi_id == IDW'(NP + j));
      for (int c = 0; c < NC; c++) begin
        if (take[c] && (cpu_id[c] == IDW'(NP + j))) s_taken[j] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dist_en_q <= 1'b0;
      s_line_q  <= '0;
      s_en_q    <= '0;
      s_cfg_q   <= '0;
      s_tgt_q   <= '0;
      s_pend    <= '0;
      s_act     <= '0;
    end else begin
      dist_en_q <= dist_en;
      s_line_q  <= shr_line;
      s_en_q    <= shr_en;
      s_cfg_q   <= shr_cfg;
      s_tgt_q   <= shr_target;
      s_pend    <= (s_pend & ~(s_taken & s_cfg_q)) | s_rise;
      s_act     <= (s_act & ~s_eoi) | (s_taken & ~s_cfg_q);
    end
  end
endmodule

// File: rtl/ipt_chk.sv
module ipt_chk #(
  parameter int NC  = 2,
  parameter int NP  = 8,
  parameter int NS  = 16,
  parameter int IDW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              dist_en,
  input logic [NC-1:0]     take_ready,
  input logic [NC-1:0]     offer_valid,
  input logic [NC*IDW-1:0] offer_id,
  input logic [NC-1:0]     offer_eoi,
  input logic [NC-1:0]     pending
);
  AST_DISABLED_NO_PENDING: assert property (@(posedge clk) disable iff (rst)
    !$past(dist_en) |-> (pending == '0)); // R4
  AST_DISABLED_NO_OFFER: assert property (@(posedge clk) disable iff (rst)
    !$past(dist_en) |-> (offer_valid == '0)); // R4

  for (genvar c = 0; c < NC; c++) begin : g_c
    AST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (rst)
      (offer_valid[c] && take_ready[c] && offer_eoi[c]) |=>
      !(offer_valid[c] && offer_id[c*IDW +: IDW] == $past(offer_id[c*IDW +: IDW]))); // R8
    AST_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
      offer_valid[c] |-> (offer_id[c*IDW +: IDW] < IDW'(NP + NS))); // R5
    for (genvar d = c + 1; d < NC; d++) begin : g_d
      AST_SHARED_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (offer_valid[c] && offer_valid[d] &&
         offer_id[c*IDW +: IDW] == offer_id[d*IDW +: IDW]) |->
        (offer_id[c*IDW +: IDW] < IDW'(NP))); // R3
    end
  end
endmodule

bind irq_pend_track ipt_chk #(.NC(NC), .NP(NP), .NS(NS), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .dist_en(dist_en), .take_ready(take_ready),
  .offer_valid(offer_valid), .offer_id(offer_id), .offer_eoi(offer_eoi),
  .pending(pending)
);

// File: tb/irq_pend_track_test.sv
`timescale 1ns/1ps
module irq_pend_track_test;
  localparam int NC = 2, NP = 8, NS = 16;
  localparam int IDW = 5, CW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dist_en = 1'b0;
  logic [NC*NP-1:0] priv_line = '0, priv_en = '0, priv_cfg = '0;
  logic [NS-1:0] shr_line = '0, shr_en = '0, shr_cfg = '0;
  logic [NC*NS-1:0] shr_target = '0;
  logic [NC-1:0] take_ready = '0;
  logic eoi_valid = 1'b0;
  logic [CW-1:0] eoi_cpu = '0;
  logic [IDW-1:0] eoi_id = '0;
  logic [NC-1:0] offer_valid, offer_eoi, pending;
  logic [NC*IDW-1:0] offer_id;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_pend_track #(.NC(NC), .NP(NP), .NS(NS)) uut (
    .clk(clk), .rst(rst), .dist_en(dist_en),
    .priv_line(priv_line), .priv_en(priv_en), .priv_cfg(priv_cfg),
    .shr_line(shr_line), .shr_en(shr_en), .shr_cfg(shr_cfg),
    .shr_target(shr_target), .take_ready(take_ready),
    .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
    .offer_valid(offer_valid), .offer_id(offer_id),
    .offer_eoi(offer_eoi), .pending(pending)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int oid(input int c);
    return int'(offer_id[c*IDW +: IDW]);
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    dist_en = 1'b1;
    priv_line = '0; priv_en = '0; priv_cfg = '0;
    shr_line = '0; shr_en = '0; shr_cfg = '0; shr_target = '0;
    take_ready = '0; eoi_valid = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic take(input int c);
    take_ready[c] = 1'b1;
    step();
    take_ready[c] = 1'b0;
  endtask

  task automatic send_eoi(input int c, input int id);
    eoi_valid = 1'b1; eoi_cpu = CW'(c); eoi_id = IDW'(id);
    step();
    eoi_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rst = 1'b1;
    priv_line[0] = 1'b1; priv_en[0] = 1'b1;
    step();
    chk("R1", "pending in reset", int'(pending), 0);
    chk("R1", "valid in reset", int'(offer_valid), 0);
    priv_line[0] = 1'b0; priv_en[0] = 1'b0;
    rst = 1'b0;
    step();
    chk("R1", "pending after reset", int'(pending), 0);
    chk("R1", "valid after reset", int'(offer_valid), 0);
  endtask

  task automatic t_private();
    do_reset();
    priv_line[3] = 1'b1;
    step();
    chk("R2", "disabled private not pending", int'(pending[0]), 0);
    priv_en[3] = 1'b1;
    step();
    chk("R2", "private valid", int'(offer_valid[0]), 1);
    chk("R2", "private id", oid(0), 3);
    chk("R2", "other cpu idle", int'(offer_valid[1]), 0);
    chk("R5", "pending equals valid", int'(pending[0]), 1);
    priv_line[1] = 1'b1; priv_en[1] = 1'b1;
    shr_line[0] = 1'b1; shr_en[0] = 1'b1; shr_target[0] = 1'b1;
    step();
    chk("R5", "lowest id wins", oid(0), 1);
    priv_line[NP+6] = 1'b1; priv_en[NP+6] = 1'b1;
    step();
    chk("R2", "cpu1 own private id", oid(1), 6);
  endtask

  task automatic t_shared();
    do_reset();
    shr_line[2] = 1'b1; shr_en[2] = 1'b1;
    shr_target[2] = 1'b1; shr_target[NS+2] = 1'b1;
    step();
    chk("R3", "cpu0 gets shared", int'(offer_valid[0]), 1);
    chk("R3", "shared id", oid(0), NP + 2);
    chk("R3", "cpu1 excluded", int'(offer_valid[1]), 0);
    shr_target[2] = 1'b0;
    step();
    chk("R3", "rerouted to cpu1", int'(offer_valid[1]), 1);
    chk("R3", "rerouted id", oid(1), NP + 2);
    chk("R3", "cpu0 dropped", int'(offer_valid[0]), 0);
    shr_en[2] = 1'b0;
    step();
    chk("R3", "disabled shared", int'(pending), 0);
  endtask

  task automatic t_disable();
    do_reset();
    priv_line[NP+4] = 1'b1; priv_en[NP+4] = 1'b1;
    step();
    chk("R4", "baseline valid", int'(offer_valid[1]), 1);
    dist_en = 1'b0;
    step();
    chk("R4", "pending off", int'(pending), 0);
    chk("R4", "valid off", int'(offer_valid), 0);
    dist_en = 1'b1;
    step();
    chk("R4", "restored", int'(pending[1]), 1);
    chk("R4", "restored id", oid(1), 4);
  endtask

  task automatic t_level();
    do_reset();
    priv_line[NP+5] = 1'b1; priv_en[NP+5] = 1'b1;
    step();
    chk("R6", "level flags eoi", int'(offer_eoi[1]), 1);
    take(1);
    chk("R8", "masked after take", int'(offer_valid[1]), 0);
    step(); step(); step();
    chk("R8", "line still ignored", int'(offer_valid[1]), 0);
    send_eoi(0, 5);
    chk("R9", "foreign eoi ignored", int'(offer_valid[1]), 0);
    send_eoi(1, 5);
    chk("R8", "resampled after eoi", int'(offer_valid[1]), 1);
    chk("R8", "resampled id", oid(1), 5);
    take(1);
    priv_line[NP+5] = 1'b0;
    send_eoi(1, 5);
    step();
    chk("R8", "low line after eoi", int'(offer_valid[1]), 0);
  endtask

  task automatic t_edge();
    do_reset();
    priv_cfg[6] = 1'b1; priv_en[6] = 1'b1;
    step();
    chk("R7", "no edge yet", int'(offer_valid[0]), 0);
    priv_line[6] = 1'b1;
    step();
    chk("R7", "edge latched", int'(offer_valid[0]), 1);
    chk("R6", "edge no eoi flag", int'(offer_eoi[0]), 0);
    take(0);
    chk("R7", "consumed", int'(offer_valid[0]), 0);
    step(); step(); step();
    chk("R7", "held high no repeat", int'(offer_valid[0]), 0);
    priv_line[6] = 1'b0;
    step();
    priv_line[6] = 1'b1;
    step();
    chk("R7", "new edge", oid(0), 6);
    chk("R7", "new edge valid", int'(offer_valid[0]), 1);
    shr_cfg[0] = 1'b1; shr_en[0] = 1'b1; shr_target[NS] = 1'b1;
    step();
    shr_line[0] = 1'b1;
    step();
    chk("R7", "shared edge id", oid(1), NP);
    take(1);
    chk("R7", "shared edge consumed", int'(offer_valid[1]), 0);
  endtask

  task automatic t_hold();
    do_reset();
    priv_cfg[2] = 1'b1; priv_en[2] = 1'b1;
    step();
    priv_line[2] = 1'b1;
    step();
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R10", "offer held", int'(offer_valid[0]), 1);
      chk("R10", "id held", oid(0), 2);
    end
    take(0);
    chk("R6", "taken on ready", int'(offer_valid[0]), 0);
  endtask

  initial begin
    t_reset();
    t_private();
    t_shared();
    t_disable();
    t_level();
    t_edge();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run hung actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule